// File: doc/BRIEF.md
# Unrolled Pipelined Vector Rotator

This block rotates a two-dimensional vector (x, y) by an angle z using shift-and-add micro-rotations. The iterations are laid out in space, not in time. Each iteration has its own processing element, and each element always does the same iteration. A register bank separates each element from the next. Because of this, the array accepts a new sample on every clock and delivers each result a fixed number of cycles later.

Each element shifts its x and y operands by a fixed distance, and that shift is plain wiring. Its angle constant is a literal built into its own z adder, so no table is read. The element picks add or subtract from the sign of the z value it receives. A valid flag travels with the data through every register bank. The block does not apply gain compensation and does not pre-rotate quadrants: the caller scales the inputs and keeps the angle within the range the micro-rotations can converge on.

Angles use binary units: one full turn equals 2^ZW, and the z field is read as two's complement.

Top module: `cordic_unrolled_array`

## Requirements
- R1: Element i looks at the sign bit of the z it receives. If that bit is 0, the element computes x' = x - (y >>> i), y' = y + (x >>> i) and z' = z - A(i). If the bit is 1, it computes x' = x + (y >>> i), y' = y - (x >>> i) and z' = z + A(i).
- R2: A sample presented with in_valid high on the clock edge n appears on the outputs with out_valid high after the clock edge n+STAGES. Samples presented on consecutive clocks come out on consecutive clocks in the same order, and none affects another.
- R3: The shifts are arithmetic, so they round toward minus infinity. The x and y results wrap modulo 2^XW in two's complement.
- R4: A(i) equals round(atan(2^-i) * 2^ZW / (2*pi)). The z results wrap modulo 2^ZW.
- R5: A z value of exactly zero counts as non-negative, so the element takes the subtracting branch of R1.
- R6: A cycle with in_valid low reaches the outputs as out_valid low, STAGES cycles later. While it is there, out_x, out_y and out_z keep the values of the last valid result (zero if no valid result has come out since reset).
- R7: A clock edge with rst_n low clears every valid flag and every data register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The input sample on this cycle is valid |
| in_x | input | XW | Input x, two's complement |
| in_y | input | XW | Input y, two's complement |
| in_z | input | ZW | Rotation angle, binary angle units |
| out_valid | output | 1 | The output sample is valid |
| out_x | output | XW | Rotated x, two's complement |
| out_y | output | XW | Rotated y, two's complement |
| out_z | output | ZW | Residual angle after the last element |

## Verification
The assertions assume that in_valid is a known level on every clock after reset, and that the data ports carry a settled value on every cycle in which in_valid is high. The bench drives every input from its own process half a period away from the sampling edge, and it sets in_valid to a defined 0 or 1 on every cycle. The bench never changes reset and data on the same edge that carries a sample. The hold checks on the outputs assume that the data inputs may change freely during bubbles, and the stimulus does change them then on purpose.

// File: rtl/cordic_pkg.sv
// Package: shared types and constant functions for the unrolled rotator.
// Assumes angles are binary: one full turn = 2^ZW, with ZW no larger than 32.
package cordic_pkg;

    localparam int MAX_STAGES = 16;
    localparam int REF_BITS   = 32;

    // Direction chosen by one micro-rotation.
    typedef enum logic {
        DIR_POS = 1'b0,   // z non-negative: rotate so as to reduce z
        DIR_NEG = 1'b1    // z negative: rotate the other way
    } rot_dir_e;

    // Purpose: atan(2^-idx) as a fraction of a full turn, scaled by 2^32.
    function automatic logic [31:0] atan_turn_q32(input int idx);
        logic [31:0] v;
        case (idx)
            0:  v = 32'd536870912;
            1:  v = 32'd316933406;
            2:  v = 32'd167458907;
            3:  v = 32'd85004756;
            4:  v = 32'd42667331;
            5:  v = 32'd21354465;
            6:  v = 32'd10679838;
            7:  v = 32'd5340245;
            8:  v = 32'd2670163;
            9:  v = 32'd1335087;
            10: v = 32'd667544;
            11: v = 32'd333772;
            12: v = 32'd166886;
            13: v = 32'd83443;
            14: v = 32'd41722;
            15: v = 32'd20861;
            default: v = 32'd0;
        endcase
        return v;
    endfunction

    // Purpose: the same angle rounded to a zw-bit turn scale.
    function automatic logic [31:0] atan_turn(input int idx, input int zw);
        logic [32:0] acc;
        acc = {1'b0, atan_turn_q32(idx)};
        if (zw >= REF_BITS) begin
            return acc[31:0];
        end
        acc = acc + (33'd1 << (REF_BITS - 1 - zw));
        acc = acc >> (REF_BITS - zw);
        return acc[31:0];
    endfunction

endpackage

// File: rtl/cordic_microrot.sv
// Module: one combinational micro-rotation element with a fixed iteration index.
// The shift by SHIFT is wiring. The angle is a literal that elaboration derives
// from SHIFT and ZW. Assumes SHIFT < XW and ZW <= 32.
module cordic_microrot
    import cordic_pkg::*;
#(
    parameter int XW    = 16,
    parameter int ZW    = 16,
    parameter int SHIFT = 0
) (
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);

    localparam logic [31:0]          ANG_FULL = atan_turn(SHIFT, ZW);
    localparam logic signed [ZW-1:0] ANGLE    = ANG_FULL[ZW-1:0];

    rot_dir_e              dir;
    logic signed [XW-1:0]  x_sh;
    logic signed [XW-1:0]  y_sh;

    // Purpose: fixed arithmetic shift of both coordinates (pure wiring).
    always_comb begin
        x_sh = x_i >>> SHIFT;
        y_sh = y_i >>> SHIFT;
    end

    // Purpose: the direction follows the sign of the incoming angle; zero counts as positive.
    always_comb begin
        dir = z_i[ZW-1] ? DIR_NEG : DIR_POS;
    end

    // Purpose: add or subtract according to the direction, wrapping at the field width.
    always_comb begin
        case (dir)
            DIR_POS: begin
                x_o = x_i - y_sh;
                y_o = y_i + x_sh;
                z_o = z_i - ANGLE;
            end
            default: begin
                x_o = x_i + y_sh;
                y_o = y_i - x_sh;
                z_o = z_i + ANGLE;
            end
        endcase
    end

endmodule

// File: rtl/cordic_stage_reg.sv
// Module: register bank between elements, carrying the valid flag and a data word.
// Data is loaded only when the flag is set, so bubbles leave it unchanged.
// Assumes vld_i is a known level after reset.
module cordic_stage_reg #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] dat_i,
    output logic         vld_o,
    output logic [W-1:0] dat_o
);

    // Purpose: the valid flag moves every cycle and reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
    end

    // Purpose: data is captured only for valid samples and cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_o <= '0;
        end else if (vld_i) begin
            dat_o <= dat_i;
        end
    end

    // R2: a valid sample advances exactly one bank per clock
    p_valid_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);

    // R6: a bubble advances as a bubble
    p_bubble_advances_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> !vld_o);

    // R6: data stays put across a bubble
    p_hold_on_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(dat_o));

    // R7: a reset edge leaves flag and data cleared
    p_reset_clears_r7: assert property (@(posedge clk)
        !rst_n |=> (!vld_o && (dat_o == '0)));

endmodule

// File: rtl/cordic_unrolled_array.sv
// Module: top of the unrolled rotator. STAGES micro-rotation elements, each
// followed by a register bank, so latency = STAGES and throughput = one per clock.
// Assumes 1 <= STAGES <= 16, STAGES < XW and ZW <= 32. There is no gain correction.
module cordic_unrolled_array
    import cordic_pkg::*;
#(
    parameter int STAGES = 4,
    parameter int XW     = 16,
    parameter int ZW     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [XW-1:0] in_x,
    input  logic signed [XW-1:0] in_y,
    input  logic signed [ZW-1:0] in_z,
    output logic                 out_valid,
    output logic signed [XW-1:0] out_x,
    output logic signed [XW-1:0] out_y,
    output logic signed [ZW-1:0] out_z
);

    localparam int DW = 2 * XW + ZW;

    logic                 v_st [STAGES+1];
    logic signed [XW-1:0] x_st [STAGES+1];
    logic signed [XW-1:0] y_st [STAGES+1];
    logic signed [ZW-1:0] z_st [STAGES+1];

    // Purpose: the inputs feed the head of the chain.
    always_comb begin
        v_st[0] = in_valid;
        x_st[0] = in_x;
        y_st[0] = in_y;
        z_st[0] = in_z;
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic signed [XW-1:0] x_n;
        logic signed [XW-1:0] y_n;
        logic signed [ZW-1:0] z_n;
        logic [DW-1:0]        word_q;

        cordic_microrot #(
            .XW    (XW),
            .ZW    (ZW),
            .SHIFT (g)
        ) u_rot (
            .x_i (x_st[g]),
            .y_i (y_st[g]),
            .z_i (z_st[g]),
            .x_o (x_n),
            .y_o (y_n),
            .z_o (z_n)
        );

        cordic_stage_reg #(
            .W (DW)
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (v_st[g]),
            .dat_i ({x_n, y_n, z_n}),
            .vld_o (v_st[g+1]),
            .dat_o (word_q)
        );

        // Purpose: unpack the registered word for the next element.
        always_comb begin
            x_st[g+1] = word_q[DW-1 -: XW];
            y_st[g+1] = word_q[ZW +: XW];
            z_st[g+1] = word_q[ZW-1:0];
        end
    end

    // Purpose: the tail of the chain drives the outputs.
    always_comb begin
        out_valid = v_st[STAGES];
        out_x     = x_st[STAGES];
        out_y     = y_st[STAGES];
        out_z     = z_st[STAGES];
    end

    // R2: the outputs never report valid during a reset cycle
    p_no_valid_in_reset_r2: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R6: the outputs keep their values while a bubble is on them
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |-> $stable(out_x) && $stable(out_y) && $stable(out_z));

endmodule

// File: tb/cordic_unrolled_array_test.sv
`timescale 1ns/1ps
module cordic_unrolled_array_test;

    localparam int STAGES = 4;
    localparam int XW     = 16;
    localparam int ZW     = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [XW-1:0] in_x = '0;
    logic signed [XW-1:0] in_y = '0;
    logic signed [ZW-1:0] in_z = '0;
    logic                 out_valid;
    logic signed [XW-1:0] out_x;
    logic signed [XW-1:0] out_y;
    logic signed [ZW-1:0] out_z;

    int n_vec  = 0;
    int n_fail = 0;

    typedef struct {
        bit    v;
        int    x;
        int    y;
        int    z;
        string tag;
    } smp_t;

    smp_t q[$];
    int   last_x = 0;
    int   last_y = 0;
    int   last_z = 0;

    always #5 clk = ~clk;

    cordic_unrolled_array #(.STAGES(STAGES), .XW(XW), .ZW(ZW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_z(out_z)
    );

    function automatic int wrapw(input int v, input int w);
        return (v <<< (32 - w)) >>> (32 - w);
    endfunction

    // Reference angle per R4, computed from real arithmetic.
    function automatic int ang(input int i);
        real r;
        r = $atan(2.0 ** (-i)) * (2.0 ** ZW) / (2.0 * 3.14159265358979323846);
        return int'($floor(r + 0.5));
    endfunction

    // Behavioural model of R1/R3/R4/R5.
    task automatic model(input int xi, input int yi, input int zi,
                         output int xo, output int yo, output int zo);
        int x, y, z, xs, ys;
        x = xi; y = yi; z = zi;
        for (int i = 0; i < STAGES; i++) begin
            xs = x >>> i;
            ys = y >>> i;
            if (z >= 0) begin
                x = wrapw(x - ys, XW); y = wrapw(y + xs, XW); z = wrapw(z - ang(i), ZW);
            end else begin
                x = wrapw(x + ys, XW); y = wrapw(y - xs, XW); z = wrapw(z + ang(i), ZW);
            end
        end
        xo = x; yo = y; zo = z;
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: compare outputs at the falling edge, then drive the next input.
    task automatic step(input bit v, input int x, input int y, input int z, input string tag);
        smp_t s;
        int ex, ey, ez;
        @(negedge clk);
        if (q.size() == STAGES) begin
            s = q.pop_front();
            if (s.v) begin
                model(s.x, s.y, s.z, ex, ey, ez);
                last_x = ex; last_y = ey; last_z = ez;
            end
            chk(s.tag, "out_valid", int'(out_valid), int'(s.v));
            chk(s.tag, "out_x", int'(out_x), last_x);
            chk(s.tag, "out_y", int'(out_y), last_y);
            chk(s.tag, "out_z", int'(out_z), last_z);
        end
        in_valid = v;
        in_x = XW'(x); in_y = XW'(y); in_z = ZW'(z);
        s.v = v; s.x = wrapw(x, XW); s.y = wrapw(y, XW); s.z = wrapw(z, ZW); s.tag = tag;
        q.push_back(s);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : main
        // R7: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7", "reset out_valid", int'(out_valid), 0);
        chk("R7", "reset out_x", int'(out_x), 0);
        chk("R7", "reset out_y", int'(out_y), 0);
        chk("R7", "reset out_z", int'(out_z), 0);
        for (int k = 0; k < STAGES; k++) begin
            smp_t s;
            s.v = 1'b0; s.x = 0; s.y = 0; s.z = 0; s.tag = "R7";
            q.push_back(s);
        end
        rst_n = 1'b1;
        // R5: zero angle takes the subtracting branch
        step(1, 10000, 0, 0, "R5");
        step(1, 0, 10000, 0, "R5");
        // R1: fixed angles of both signs, back to back
        step(1, 9000, 0, 8192, "R1");
        step(1, 9000, 0, -8192, "R1");
        step(1, 5000, -7000, 3000, "R1");
        step(1, -6000, 4000, -12000, "R1");
        // R3: negative operands with odd values (floor shift) and wrap at full scale
        step(1, -1, -3, 100, "R3");
        step(1, 32767, 32767, 16000, "R3");
        step(1, -32768, -32768, -16000, "R3");
        // R4: angle wrap near half a turn
        step(1, 1000, 1000, 32767, "R4");
        step(1, 1000, 1000, -32768, "R4");
        // R6: bubbles with changing data must be ignored
        for (int k = 0; k < 6; k++) step(0, 1234 * k, -999, 777 * k, "R6");
        step(1, 3000, 3000, 4000, "R6");
        step(0, 1, 2, 3, "R6");
        step(0, 4, 5, 6, "R6");
        // R2: long back-to-back stream with sporadic bubbles
        for (int k = 0; k < 300; k++) begin
            step(($urandom % 5) != 0, int'($urandom % 65536) - 32768,
                 int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768, "R2");
        end
        // R7: reset mid-stream clears everything
        step(1, 4444, 5555, 6666, "R2");
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R7", "mid reset out_valid", int'(out_valid), 0);
        chk("R7", "mid reset out_x", int'(out_x), 0);
        chk("R7", "mid reset out_z", int'(out_z), 0);
        rst_n = 1'b1;
        q.delete();
        last_x = 0; last_y = 0; last_z = 0;
        for (int k = 0; k < STAGES; k++) begin
            smp_t s;
            s.v = 1'b0; s.x = 0; s.y = 0; s.z = 0; s.tag = "R7";
            q.push_back(s);
        end
        for (int k = 0; k < STAGES + 2; k++) step(0, 0, 0, 0, "R7");
        step(1, 2000, -2000, 5000, "R2");
        for (int k = 0; k < STAGES + 1; k++) step(0, 0, 0, 0, "R2");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule